// File: doc/BRIEF.md
# Token-Chained Event Readout Slave

This block is the slave end of a chained block-read on a VME-style backplane. A controller opens a readout cycle by lowering the address strobe with address modifier 0x1B, a 32-bit read qualifier (A01 low, LWORD active, WRITE inactive) and a 4-bit event tag on A05..A02. Every slave that holds words for that event then pulls a shared wired-OR "words pending" line. Only one slave serves data at a time. It is the one whose enable input from the previous module is active while its own enable output is still inactive. When it has no words left, it hands the token on by raising its enable output, and it lets go of the pending line.

Event words come from a local first-in first-out store, pushed in time order, each with an event tag and an end-of-event flag. The block treats itself as holding data for a cycle only when the oldest stored word carries the requested tag. In every other case it passes the token straight on. All bus inputs are brought into the clock domain through two flip-flops. With a 5 ns clock, the response limits are met by counting cycles.

Top module: `chain_readout_slave`

## Requirements
- R1: After reset, busy_drive, en_out, dtack_drive and data_oe are 0, data_out is 0 and push_ready is 1.
- R2: A cycle is taken up only when as_n=0, am=0x1B, bus_addr[1]=0, lword_n=0 and write_n=1. With any other combination, busy_drive and en_out stay 0 for the whole strobe, even when en_in_n is active.
- R3: When the oldest stored word's tag equals bus_addr[5:2], busy_drive rises exactly 3 clock edges after as_n falls (15 ns, within the 200 ns limit).
- R4: When the store is empty or the oldest tag differs from bus_addr[5:2], busy_drive stays 0. en_out rises 3 edges after en_in_n is active.
- R5: en_out is asserted only after en_in_n has been seen active and no word for the event remains.
- R6: data_oe, data_out and dtack_drive respond only while en_in_n=0 and both ds_n bits are 0. data_oe and the word appear one cycle before dtack_drive, and dtack_drive drops once either strobe is released.
- R7: A word is consumed when both strobes are released after its acknowledge. After a word without the end flag, busy_drive stays 1 and en_out stays 0. After the end-flagged word, en_out rises and busy_drive falls in the same cycle, and only once both strobes are released.
- R8: Once asserted, en_out stays 1 until as_n goes high.
- R9: When as_n goes high, every driven output returns to 0 within 3 edges (well inside 50 ns). A word whose strobes were still held at that moment is not consumed.
- R10: Words leave in push order. push_ready is 0 when DEPTH words are stored, and a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 2 | Data strobes, active low |
| lword_n | input | 1 | Long-word qualifier, active low |
| write_n | input | 1 | Write select, active low (high means read) |
| am | input | 6 | Address modifier |
| bus_addr | input | 5 | Address lines A05..A01; A05..A02 carry the event tag |
| en_in_n | input | 1 | Readout enable from the previous module, active low |
| en_out | output | 1 | 1 = drive the enable to the next module |
| busy_drive | output | 1 | 1 = pull the shared words-pending line |
| dtack_drive | output | 1 | 1 = pull the data acknowledge |
| data_oe | output | 1 | 1 = drive data_out onto the data bus |
| data_out | output | DATA_W | Word being returned, 0 when not driven |
| push_valid | input | 1 | Store a word this cycle |
| push_data | input | DATA_W | Word to store |
| push_tag | input | 4 | Event tag of the word |
| push_last | input | 1 | Word ends its event |
| push_ready | output | 1 | Store has room |

## Verification
Two actions can compete in one cycle. The release of both strobes after an acknowledge consumes the word, and the release of the address strobe aborts the cycle. The abort takes priority. The bench provokes the overlap by raising as_n while an acknowledged word still has its strobes held. It then judges the result by opening a new cycle for the same event: busy_drive must return and the same word must be read again. A second overlap is the end-flagged word's strobe release, which must assert en_out and drop busy_drive on the same edge. That case is judged by sampling both outputs one edge before and at the edge.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
    localparam logic [5:0] AM_READOUT = 6'h1B;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NODATA,
        ST_HOLD,
        ST_DATA,
        ST_ACK,
        ST_PASS
    } rd_state_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/event_fifo.sv
module event_fifo #(
    parameter int DW    = 32,
    parameter int TW    = 4,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic [TW-1:0] push_tag,
    input  logic          push_last,
    output logic          push_ready,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [TW-1:0] head_tag,
    output logic          head_last,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int EW = DW + TW + 1;

    logic [EW-1:0] mem [DEPTH];
    logic [AW:0]   wptr_q, wptr_d;
    logic [AW:0]   rptr_q, rptr_d;
    logic          full;
    logic          do_push;
    logic          do_pop;

    assign empty   = (wptr_q == rptr_q);
    assign full    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign push_ready = !full;

    always_comb begin
        wptr_d = wptr_q + (AW+1)'(do_push);
        rptr_d = rptr_q + (AW+1)'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            wptr_q <= wptr_d;
            rptr_q <= rptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q[AW-1:0]] <= {push_last, push_tag, push_data};
    end

    assign {head_last, head_tag, head_data} = mem[rptr_q[AW-1:0]];
endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
    import chain_rd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_as,
    input  logic          s_ds_both,
    input  logic          s_ds_none,
    input  logic          s_en,
    input  logic          cycle_ok,
    input  logic          has_data,
    input  logic          empty,
    input  logic [DW-1:0] head_data,
    input  logic          head_last,
    output logic          pop,
    output logic          busy,
    output logic          pass,
    output logic          dtack,
    output logic          oe,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        rd_state_e     state;
        logic          busy;
        logic          pass;
        logic          dtack;
        logic          oe;
        logic [DW-1:0] dout;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  pop_d;

    always_comb begin
        ctl_d = ctl_q;
        pop_d = 1'b0;
        if (!s_as) begin
            ctl_d.state = ST_IDLE;
            ctl_d.busy  = 1'b0;
            ctl_d.pass  = 1'b0;
            ctl_d.dtack = 1'b0;
            ctl_d.oe    = 1'b0;
            ctl_d.dout  = '0;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    if (cycle_ok) begin
                        if (has_data) begin
                            ctl_d.state = ST_HOLD;
                            ctl_d.busy  = 1'b1;
                        end else begin
                            ctl_d.state = ST_NODATA;
                        end
                    end
                end
                ST_NODATA: begin
                    if (s_en) begin
                        ctl_d.state = ST_PASS;
                        ctl_d.pass  = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (s_en && s_ds_both && !empty) begin
                        ctl_d.state = ST_DATA;
                        ctl_d.oe    = 1'b1;
                        ctl_d.dout  = head_data;
                    end
                end
                ST_DATA: begin
                    if (s_en && s_ds_both) begin
                        ctl_d.state = ST_ACK;
                        ctl_d.dtack = 1'b1;
                    end else begin
                        ctl_d.state = ST_HOLD;
                        ctl_d.oe    = 1'b0;
                        ctl_d.dout  = '0;
                    end
                end
                ST_ACK: begin
                    ctl_d.dtack = s_en && s_ds_both;
                    if (s_ds_none) begin
                        pop_d       = 1'b1;
                        ctl_d.dtack = 1'b0;
                        ctl_d.oe    = 1'b0;
                        ctl_d.dout  = '0;
                        if (head_last) begin
                            ctl_d.state = ST_PASS;
                            ctl_d.busy  = 1'b0;
                            ctl_d.pass  = 1'b1;
                        end else begin
                            ctl_d.state = ST_HOLD;
                        end
                    end
                end
                ST_PASS: begin
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, busy: 1'b0, pass: 1'b0, dtack: 1'b0,
                       oe: 1'b0, dout: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pop   = pop_d;
    assign busy  = ctl_q.busy;
    assign pass  = ctl_q.pass;
    assign dtack = ctl_q.dtack;
    assign oe    = ctl_q.oe;
    assign dout  = ctl_q.dout;
endmodule

// File: rtl/chain_readout_slave.sv
module chain_readout_slave
    import chain_rd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic [1:0]        ds_n,
    input  logic              lword_n,
    input  logic              write_n,
    input  logic [5:0]        am,
    input  logic [5:1]        bus_addr,
    input  logic              en_in_n,
    output logic              en_out,
    output logic              busy_drive,
    output logic              dtack_drive,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic [3:0]        push_tag,
    input  logic              push_last,
    output logic              push_ready
);
    localparam int TAG_W  = 4;
    localparam int CTRL_W = 6;
    localparam int SYNC_W = CTRL_W + 6 + 5;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{CTRL_W{1'b1}}, 11'b0};

    logic [SYNC_W-1:0] raw_in, syn_out;
    logic              s_as_n, s_lword_n, s_write_n, s_en_n;
    logic [1:0]        s_ds_n;
    logic [5:0]        s_am;
    logic [5:1]        s_addr;

    assign raw_in = {as_n, ds_n, lword_n, write_n, en_in_n, am, bus_addr};

    bus_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_out)
    );

    assign {s_as_n, s_ds_n, s_lword_n, s_write_n, s_en_n, s_am, s_addr} = syn_out;

    logic              cycle_ok, has_data, pop, empty, head_last;
    logic [DATA_W-1:0] head_data;
    logic [TAG_W-1:0]  head_tag;

    assign cycle_ok = !s_as_n && (s_am == AM_READOUT) && !s_addr[1]
                      && !s_lword_n && s_write_n;
    assign has_data = !empty && (head_tag == s_addr[5:2]);

    event_fifo #(.DW(DATA_W), .TW(TAG_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_valid),
        .push_data  (push_data),
        .push_tag   (push_tag),
        .push_last  (push_last),
        .push_ready (push_ready),
        .pop        (pop),
        .head_data  (head_data),
        .head_tag   (head_tag),
        .head_last  (head_last),
        .empty      (empty)
    );

    readout_ctrl #(.DW(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_as      (!s_as_n),
        .s_ds_both (s_ds_n == 2'b00),
        .s_ds_none (s_ds_n == 2'b11),
        .s_en      (!s_en_n),
        .cycle_ok  (cycle_ok),
        .has_data  (has_data),
        .empty     (empty),
        .head_data (head_data),
        .head_last (head_last),
        .pop       (pop),
        .busy      (busy_drive),
        .pass      (en_out),
        .dtack     (dtack_drive),
        .oe        (data_oe),
        .dout      (data_out)
    );
endmodule

// File: rtl/chain_readout_slave_chk.sv
module chain_readout_slave_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              as_n,
    input logic [1:0]        ds_n,
    input logic              en_in_n,
    input logic [5:0]        am,
    input logic              en_out,
    input logic              busy_drive,
    input logic              dtack_drive,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out
);
    AST_RESPONSE_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_drive) |-> !$past(as_n, 3) && ($past(am, 3) == 6'h1B)); // R2

    AST_PASS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_out) |-> !$past(en_in_n, 3)); // R5

    AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_drive |-> !$past(en_in_n, 3) && ($past(ds_n, 3) == 2'b00)); // R6

    AST_DATA_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_drive) |-> $past(data_oe) && data_oe && $stable(data_out)); // R6

    AST_NO_ACK_WHEN_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_drive |-> !en_out); // R6

    AST_BUSY_PASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_drive && en_out)); // R7

    AST_PASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_out) |-> $past(as_n, 3)); // R8

    AST_RELEASE_ON_AS: assert property (@(posedge clk) disable iff (!rst_n)
        as_n && $past(as_n) && $past(as_n, 2) && $past(as_n, 3)
        |-> !busy_drive && !en_out && !dtack_drive && !data_oe); // R9
endmodule

bind chain_readout_slave chain_readout_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .as_n        (as_n),
    .ds_n        (ds_n),
    .en_in_n     (en_in_n),
    .am          (am),
    .en_out      (en_out),
    .busy_drive  (busy_drive),
    .dtack_drive (dtack_drive),
    .data_oe     (data_oe),
    .data_out    (data_out)
);

// File: tb/sim_chain_readout_slave.sv
`timescale 1ns/1ps
module sim_chain_readout_slave;
    localparam int DW    = 32;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          as_n = 1'b1;
    logic [1:0]    ds_n = 2'b11;
    logic          lword_n = 1'b0;
    logic          write_n = 1'b1;
    logic [5:0]    am = 6'h1B;
    logic [5:1]    bus_addr = '0;
    logic          en_in_n = 1'b1;
    logic          en_out, busy_drive, dtack_drive, data_oe, push_ready;
    logic [DW-1:0] data_out;
    logic          push_valid = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [3:0]    push_tag = '0;
    logic          push_last = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chain_readout_slave #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .lword_n(lword_n),
        .write_n(write_n), .am(am), .bus_addr(bus_addr), .en_in_n(en_in_n),
        .en_out(en_out), .busy_drive(busy_drive), .dtack_drive(dtack_drive),
        .data_oe(data_oe), .data_out(data_out), .push_valid(push_valid),
        .push_data(push_data), .push_tag(push_tag), .push_last(push_last),
        .push_ready(push_ready)
    );

    // {am[5:0], a01, lword_n, write_n, expect_taken}
    localparam logic [9:0] DECODE_VEC [0:6] = '{
        {6'h1B, 1'b0, 1'b0, 1'b1, 1'b1},
        {6'h1A, 1'b0, 1'b0, 1'b1, 1'b0},
        {6'h0B, 1'b0, 1'b0, 1'b1, 1'b0},
        {6'h1B, 1'b1, 1'b0, 1'b1, 1'b0},
        {6'h1B, 1'b0, 1'b1, 1'b1, 1'b0},
        {6'h1B, 1'b0, 1'b0, 1'b0, 1'b0},
        {6'h1B, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d, input logic [3:0] t, input logic l);
        push_valid = 1'b1; push_data = d; push_tag = t; push_last = l;
        step(1);
        push_valid = 1'b0;
    endtask

    task automatic open_cycle(input logic [3:0] ev);
        bus_addr = {ev, 1'b0};
        as_n = 1'b0;
    endtask

    task automatic close_cycle();
        as_n = 1'b1; en_in_n = 1'b1; ds_n = 2'b11;
        step(4);
    endtask

    task automatic read_word(input string req, input logic [DW-1:0] exp, input logic last);
        ds_n = 2'b00;
        step(4);
        chk(req, "word", data_out, exp);
        chk(req, "ack", 32'(dtack_drive), 32'd1);
        ds_n = 2'b11;
        step(3);
        chk(req, "pass after word", 32'(en_out), 32'(last));
        chk(req, "busy after word", 32'(busy_drive), 32'(!last));
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", "busy", 32'(busy_drive), 0);
        chk("R1", "pass", 32'(en_out), 0);
        chk("R1", "ack", 32'(dtack_drive), 0);
        chk("R1", "oe", 32'(data_oe), 0);
        chk("R1", "data", data_out, 0);
        chk("R1", "ready", 32'(push_ready), 1);

        push(32'hA0A0_0001, 4'd3, 1'b0);
        push(32'hB0B0_0002, 4'd3, 1'b1);
        push(32'hC0C0_0003, 4'd4, 1'b1);

        // R2 decode table, enable held active
        for (int i = 0; i < 7; i++) begin
            am = DECODE_VEC[i][9:4];
            lword_n = DECODE_VEC[i][2];
            write_n = DECODE_VEC[i][1];
            en_in_n = 1'b0;
            bus_addr = {4'd3, DECODE_VEC[i][3]};
            as_n = 1'b0;
            step(6);
            chk("R2", "busy per decode", 32'(busy_drive), 32'(DECODE_VEC[i][0]));
            chk("R2", "no pass", 32'(en_out), 0);
            close_cycle();
            am = 6'h1B; lword_n = 1'b0; write_n = 1'b1;
        end

        // R3 busy latency for matching event
        open_cycle(4'd3);
        step(2);
        chk("R3", "busy early", 32'(busy_drive), 0);
        step(1);
        chk("R3", "busy at 3", 32'(busy_drive), 1);
        // R6 strobes without enable do nothing
        ds_n = 2'b00;
        step(4);
        chk("R6", "oe without enable", 32'(data_oe), 0);
        chk("R6", "ack without enable", 32'(dtack_drive), 0);
        en_in_n = 1'b0;
        step(3);
        chk("R6", "oe before ack", 32'(data_oe), 1);
        chk("R6", "ack later", 32'(dtack_drive), 0);
        chk("R10", "first word", data_out, 32'hA0A0_0001);
        step(1);
        chk("R6", "ack", 32'(dtack_drive), 1);
        ds_n = 2'b01;
        step(3);
        chk("R6", "ack drops on one strobe", 32'(dtack_drive), 0);
        chk("R7", "no pass half release", 32'(en_out), 0);
        ds_n = 2'b11;
        step(3);
        chk("R7", "still busy", 32'(busy_drive), 1);
        chk("R7", "no pass mid event", 32'(en_out), 0);
        chk("R6", "data released", 32'(data_oe), 0);
        ds_n = 2'b00;
        step(4);
        chk("R10", "second word", data_out, 32'hB0B0_0002);
        step(5);
        chk("R7", "pass waits strobes", 32'(en_out), 0);
        chk("R7", "busy waits strobes", 32'(busy_drive), 1);
        ds_n = 2'b11;
        step(2);
        chk("R7", "pass not yet", 32'(en_out), 0);
        step(1);
        chk("R7", "pass with release", 32'(en_out), 1);
        chk("R7", "busy drops together", 32'(busy_drive), 0);
        ds_n = 2'b00;
        step(10);
        chk("R8", "pass held", 32'(en_out), 1);
        chk("R6", "no ack after pass", 32'(dtack_drive), 0);
        as_n = 1'b1; en_in_n = 1'b1; ds_n = 2'b11;
        step(3);
        chk("R9", "pass dropped", 32'(en_out), 0);
        step(2);

        // R9 abort with strobes still held, then reread
        open_cycle(4'd4);
        en_in_n = 1'b0; ds_n = 2'b00;
        step(6);
        chk("R9", "acked before abort", 32'(dtack_drive), 1);
        as_n = 1'b1;
        step(3);
        chk("R9", "ack released", 32'(dtack_drive), 0);
        chk("R9", "oe released", 32'(data_oe), 0);
        chk("R9", "busy released", 32'(busy_drive), 0);
        ds_n = 2'b11; en_in_n = 1'b1;
        step(3);
        open_cycle(4'd4);
        step(3);
        chk("R9", "word kept after abort", 32'(busy_drive), 1);
        en_in_n = 1'b0;
        read_word("R9", 32'hC0C0_0003, 1'b1);
        close_cycle();

        // R4 empty store
        open_cycle(4'd4);
        step(5);
        chk("R4", "no busy when empty", 32'(busy_drive), 0);
        chk("R5", "no pass before enable", 32'(en_out), 0);
        en_in_n = 1'b0;
        step(3);
        chk("R4", "pass through", 32'(en_out), 1);
        close_cycle();

        // R4 tag mismatch with data present
        push(32'hD0D0_0004, 4'd9, 1'b1);
        open_cycle(4'd2);
        en_in_n = 1'b0;
        step(6);
        chk("R4", "no busy on mismatch", 32'(busy_drive), 0);
        chk("R4", "pass on mismatch", 32'(en_out), 1);
        close_cycle();
        open_cycle(4'd9);
        en_in_n = 1'b0;
        step(3);
        read_word("R10", 32'hD0D0_0004, 1'b1);
        close_cycle();

        // R10 fill, overflow drop, order
        for (int i = 0; i < DEPTH; i++) push(32'h6000_0000 + 32'(i), 4'd6, i == DEPTH - 1);
        chk("R10", "full", 32'(push_ready), 0);
        push(32'h7777_7777, 4'd7, 1'b1);
        open_cycle(4'd6);
        en_in_n = 1'b0;
        step(3);
        for (int i = 0; i < DEPTH; i++)
            read_word("R10", 32'h6000_0000 + 32'(i), i == DEPTH - 1);
        close_cycle();
        chk("R10", "ready again", 32'(push_ready), 1);
        open_cycle(4'd7);
        step(5);
        chk("R10", "dropped push absent", 32'(busy_drive), 0);
        close_cycle();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule